// File: doc/BRIEF.md
# Byte-Stream Register Bus Bridge

This block lets a host that speaks only in bytes reach the registers on a chip's internal synchronous bus. Bytes arrive one at a time from a byte FIFO (for instance the receive side of a USB-to-FIFO converter). The bridge assembles them into fixed-length command packets and carries out one 16-bit bus access per packet. For a read, it returns the 16-bit result as two bytes through the transmit side of the same FIFO.

A packet opens with one command byte: 0x57 requests a write and 0x52 requests a read. Three address bytes follow, most significant first. Bits 23:20 of the 24 received bits carry no meaning, and only bits 10:0 reach the bus. A write packet then carries two data bytes, high byte first. A read answer is likewise sent high byte first.

Both byte interfaces are valid/ready streams. A byte moves on a rising edge where valid and ready are both high. The bridge lowers `rx_ready` while a fully parsed command is still waiting for the bus, which holds the FIFO back. The host side lowers `tx_ready` to stall the answer; `tx_valid` and `tx_data` then stay put. The bus side is a plain master port. Three stages (parser, bus sequencer, byte serializer) work at the same time, so the next packet can be received while the previous answer drains.

Top module: `bytecmd_bridge`

## Requirements
- R1: A packet of 0x57 followed by three address bytes and two data bytes (high byte first) produces exactly one cycle with `bus_wr` high, carrying `bus_addr` equal to address bits 10:0 and `bus_wdata` equal to the data word.
- R2: A packet of 0x52 followed by three address bytes produces one bus read; the word read is then emitted on `tx_data` as two bytes, bits 15:8 first, then bits 7:0.
- R3: For a read, `bus_addr` already carries the read address in the cycle before `bus_rd` rises and keeps it while `bus_rd` is high. `bus_rd` is high for one cycle only, and `bus_rdata` is taken on the rising edge that ends that cycle.
- R4: Received address bits 23:11 have no effect: packets whose addresses differ only there reach the same bus register.
- R5: A command byte other than 0x57 or 0x52 is consumed and dropped, with no bus access and no output. The next byte is again treated as a command byte.
- R6: A byte is taken only on an edge where `rx_valid` and `rx_ready` are both high. While a complete command waits for the bus sequencer, `rx_ready` is low.
- R7: Once `tx_valid` is high, it stays high and `tx_data` stays unchanged until an edge with `tx_ready` high; each response byte is transferred exactly once.
- R8: `bus_wr` and `bus_rd` are never high together, and `bus_wr` is high for a single cycle per write packet.
- R9: After reset, `rx_ready` is high and `tx_valid`, `bus_wr` and `bus_rd` are low.
- R10: Bus accesses and response bytes follow packet order, even when a packet is received or executed while an earlier read answer is still stalled on `tx_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_valid | input | 1 | A received byte is available |
| rx_ready | output | 1 | Bridge takes the byte on this edge |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | A response byte is offered |
| tx_ready | input | 1 | Sink accepts the offered byte |
| tx_data | output | 8 | Response byte |
| bus_addr | output | 11 | Internal bus address |
| bus_wdata | output | 16 | Internal bus write data |
| bus_wr | output | 1 | Write strobe, one cycle |
| bus_rd | output | 1 | Read strobe, one cycle |
| bus_rdata | input | 16 | Read data, valid while the read strobe is high |

## Verification
The risky overlap is a bus access and the transfer or stall of a response byte falling in the same cycle. This happens when a write or a second read runs while an earlier answer is held back by a low `tx_ready`. The bench provokes it by stalling the sink through two reads and two writes, then later releasing it with a pseudo-random `tx_ready` pattern during a stream of random packets. The bench's peripheral model answers reads only one cycle after it sees the address, so a violated address lead shows up as wrong read data. Every bus strobe and every transferred byte is compared in order against queues filled from the packets sent, and the bench confirms that `rx_ready` drops while the fourth command is parked.

// File: rtl/bbr_pkg.sv
package bbr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [7:0] OP_WRITE = 8'h57;
  localparam logic [7:0] OP_READ  = 8'h52;

  typedef enum logic [1:0] {PS_CMD, PS_ADDR, PS_DATA, PS_HOLD} parse_st_e;
  typedef enum logic [2:0] {BS_IDLE, BS_WRITE, BS_RADDR, BS_RSTB, BS_RESP} bus_st_e;
endpackage

// File: rtl/bbr_parser.sv
module bbr_parser
  import bbr_pkg::*;
#(
  parameter int PKT_ADDR_W = 20,
  parameter int BUS_ADDR_W = 11,
  parameter int DATA_W     = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [BYTE_W-1:0]     in_byte,
  output logic                  cmd_valid,
  input  logic                  cmd_ready,
  output logic                  cmd_write,
  output logic [BUS_ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0]     cmd_data
);
  localparam int ADDR_BYTES = (PKT_ADDR_W + BYTE_W - 1) / BYTE_W;
  localparam int DATA_BYTES = (DATA_W + BYTE_W - 1) / BYTE_W;
  localparam int SH_A_W     = ADDR_BYTES * BYTE_W;
  localparam int SH_D_W     = DATA_BYTES * BYTE_W;
  localparam int MAX_BYTES  = (ADDR_BYTES > DATA_BYTES) ? ADDR_BYTES : DATA_BYTES;
  localparam int CNT_W      = $clog2(MAX_BYTES + 1);

  parse_st_e         state;
  logic [CNT_W-1:0]  cnt;
  logic              is_wr;
  logic [SH_A_W-1:0] addr_sh;
  logic [SH_D_W-1:0] data_sh;
  logic              take;

  assign in_ready  = (state != PS_HOLD);
  assign take      = in_valid && in_ready;
  assign cmd_valid = (state == PS_HOLD);
  assign cmd_write = is_wr;
  assign cmd_addr  = addr_sh[BUS_ADDR_W-1:0];
  assign cmd_data  = data_sh[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= PS_CMD;
      cnt     <= '0;
      is_wr   <= 1'b0;
      addr_sh <= '0;
      data_sh <= '0;
    end else begin
      case (state)
        PS_CMD: begin
          if (take && (in_byte == OP_WRITE || in_byte == OP_READ)) begin
            is_wr <= (in_byte == OP_WRITE);
            cnt   <= CNT_W'(ADDR_BYTES - 1);
            state <= PS_ADDR;
          end
        end
        PS_ADDR: begin
          if (take) begin
            addr_sh <= (addr_sh << BYTE_W) | SH_A_W'(in_byte);
            if (cnt == '0) begin
              if (is_wr) begin
                cnt   <= CNT_W'(DATA_BYTES - 1);
                state <= PS_DATA;
              end else begin
                state <= PS_HOLD;
              end
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        PS_DATA: begin
          if (take) begin
            data_sh <= (data_sh << BYTE_W) | SH_D_W'(in_byte);
            if (cnt == '0) state <= PS_HOLD;
            else           cnt   <= cnt - 1'b1;
          end
        end
        PS_HOLD: begin
          if (cmd_ready) state <= PS_CMD;
        end
        default: state <= PS_CMD;
      endcase
    end
  end

  // R6: a parked command keeps its fields until the sequencer takes it
  assert_cmd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_data)
                                && $stable(cmd_write));
endmodule

// File: rtl/bbr_bus_seq.sv
module bbr_bus_seq
  import bbr_pkg::*;
#(
  parameter int BUS_ADDR_W = 11,
  parameter int DATA_W     = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic                  cmd_write,
  input  logic [BUS_ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0]     cmd_data,
  output logic [BUS_ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0]     bus_wdata,
  output logic                  bus_wr,
  output logic                  bus_rd,
  input  logic [DATA_W-1:0]     bus_rdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [DATA_W-1:0]     rsp_data
);
  bus_st_e                state;
  logic [BUS_ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]      wdata_q;
  logic [DATA_W-1:0]      rsp_q;

  assign cmd_ready = (state == BS_IDLE);
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
  assign bus_wr    = (state == BS_WRITE);
  assign bus_rd    = (state == BS_RSTB);
  assign rsp_valid = (state == BS_RESP);
  assign rsp_data  = rsp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= BS_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rsp_q   <= '0;
    end else begin
      case (state)
        BS_IDLE: begin
          if (cmd_valid) begin
            addr_q  <= cmd_addr;
            wdata_q <= cmd_data;
            state   <= cmd_write ? BS_WRITE : BS_RADDR;
          end
        end
        BS_WRITE: state <= BS_IDLE;
        BS_RADDR: state <= BS_RSTB;
        BS_RSTB: begin
          rsp_q <= bus_rdata;
          state <= BS_RESP;
        end
        BS_RESP: begin
          if (rsp_ready) state <= BS_IDLE;
        end
        default: state <= BS_IDLE;
      endcase
    end
  end

  // R3: address leads the read strobe and the strobe lasts one cycle
  assert_rd_addr_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> $stable(bus_addr));
  assert_rd_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> !bus_rd);
  // R8: strobes exclusive, write strobe single
  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));
  assert_wr_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> !bus_wr);
  // R10: a waiting answer word is held until the serializer takes it
  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
endmodule

// File: rtl/bbr_tx_ser.sv
module bbr_tx_ser
  import bbr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_word,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_byte
);
  localparam int DATA_BYTES = (DATA_W + BYTE_W - 1) / BYTE_W;
  localparam int SH_W       = DATA_BYTES * BYTE_W;
  localparam int PAD        = SH_W - DATA_W;
  localparam int CNT_W      = $clog2(DATA_BYTES + 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [SH_W-1:0]  sh;

  assign in_ready = !busy;
  assign tx_valid = busy;
  assign tx_byte  = sh[SH_W-1 -: BYTE_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      sh   <= '0;
    end else if (!busy) begin
      if (in_valid) begin
        sh   <= SH_W'(in_word) << PAD;
        cnt  <= CNT_W'(DATA_BYTES - 1);
        busy <= 1'b1;
      end
    end else if (tx_ready) begin
      sh <= sh << BYTE_W;
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  // R7: offered byte held steady under back-pressure
  assert_tx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte));
endmodule

// File: rtl/bytecmd_bridge.sv
module bytecmd_bridge
  import bbr_pkg::*;
#(
  parameter int PKT_ADDR_W = 20,
  parameter int BUS_ADDR_W = 11,
  parameter int DATA_W     = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rx_valid,
  output logic                  rx_ready,
  input  logic [7:0]            rx_data,
  output logic                  tx_valid,
  input  logic                  tx_ready,
  output logic [7:0]            tx_data,
  output logic [BUS_ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0]     bus_wdata,
  output logic                  bus_wr,
  output logic                  bus_rd,
  input  logic [DATA_W-1:0]     bus_rdata
);
  logic                  cmd_valid;
  logic                  cmd_ready;
  logic                  cmd_write;
  logic [BUS_ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0]     cmd_data;
  logic                  rsp_valid;
  logic                  rsp_ready;
  logic [DATA_W-1:0]     rsp_data;

  bbr_parser #(
    .PKT_ADDR_W(PKT_ADDR_W),
    .BUS_ADDR_W(BUS_ADDR_W),
    .DATA_W    (DATA_W)
  ) u_parser (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (rx_valid),
    .in_ready (rx_ready),
    .in_byte  (rx_data),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_write(cmd_write),
    .cmd_addr (cmd_addr),
    .cmd_data (cmd_data)
  );

  bbr_bus_seq #(
    .BUS_ADDR_W(BUS_ADDR_W),
    .DATA_W    (DATA_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_write(cmd_write),
    .cmd_addr (cmd_addr),
    .cmd_data (cmd_data),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_rdata(bus_rdata),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_data (rsp_data)
  );

  bbr_tx_ser #(
    .DATA_W(DATA_W)
  ) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(rsp_valid),
    .in_ready(rsp_ready),
    .in_word (rsp_data),
    .tx_valid(tx_valid),
    .tx_ready(tx_ready),
    .tx_byte (tx_data)
  );

  // R6: no byte may be taken while a parsed command is parked
  assert_rx_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> !rx_ready);
endmodule

// File: tb/bytecmd_bridge_bench.sv
module bytecmd_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_data = 8'h00;
  logic        tx_valid;
  logic        tx_ready = 1'b1;
  logic [7:0]  tx_data;
  logic [10:0] bus_addr;
  logic [15:0] bus_wdata;
  logic        bus_wr;
  logic        bus_rd;
  logic [15:0] bus_rdata = 16'h0000;

  bytecmd_bridge u_bytecmd_bridge (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int failures = 0;
  int tx_mode = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  int cyc = 0;

  logic [15:0] per_mem [0:2047];
  logic [15:0] ref_mem [0:2047];
  logic [26:0] exp_wr [$];
  logic [7:0]  exp_tx [$];

  initial begin
    for (int i = 0; i < 2048; i++) begin
      per_mem[i] = 16'h0000;
      ref_mem[i] = 16'h0000;
    end
  end

  // peripheral: answers one cycle after it sees the address
  always @(posedge clk) begin
    bus_rdata <= per_mem[bus_addr];
    if (bus_wr) per_mem[bus_addr] <= bus_wdata;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // sink back-pressure pattern
  always @(negedge clk) begin
    case (tx_mode)
      0: tx_ready <= 1'b1;
      1: tx_ready <= ($urandom_range(0, 2) != 0);
      default: tx_ready <= 1'b0;
    endcase
  end

  // per-cycle monitor against the reference queues
  logic        prev_rd = 1'b0;
  logic [10:0] prev_addr = '0;
  bit          hold_pend = 1'b0;
  logic [7:0]  hold_byte = '0;
  always @(negedge clk) begin
    #3;
    if (mon_on) begin
      if (bus_wr && bus_rd) chk(1'b0, "R8 strobes together", 1, 0);
      if (bus_wr) begin
        if (exp_wr.size() == 0) chk(1'b0, "R1/R5 unexpected bus write", {5'd0, bus_addr, bus_wdata}, 0);
        else begin
          chk({bus_addr, bus_wdata} == exp_wr[0], "R1 R4 R10 bus write",
              {5'd0, bus_addr, bus_wdata}, {5'd0, exp_wr[0]});
          void'(exp_wr.pop_front());
        end
      end
      if (bus_rd) begin
        chk(bus_addr == prev_addr && !prev_rd, "R3 read address lead",
            {prev_rd, bus_addr}, {1'b0, prev_addr});
      end
      if (hold_pend) begin
        chk(tx_valid && tx_data == hold_byte, "R7 stalled byte held",
            {tx_valid, tx_data}, {1'b1, hold_byte});
      end
      hold_pend = tx_valid && !tx_ready;
      hold_byte = tx_data;
      if (tx_valid && tx_ready) begin
        if (exp_tx.size() == 0) chk(1'b0, "R5 unexpected tx byte", tx_data, 0);
        else begin
          chk(tx_data == exp_tx[0], "R2 R10 response byte", tx_data, exp_tx[0]);
          void'(exp_tx.pop_front());
        end
      end
      prev_rd = bus_rd;
      prev_addr = bus_addr;
    end
  end

  task automatic put_byte(input logic [7:0] b, input int gap);
    bit acc;
    repeat (gap) @(negedge clk);
    rx_valid = 1'b1;
    rx_data = b;
    acc = 1'b0;
    while (!acc) begin
      #3;
      acc = rx_ready;
      @(negedge clk);
    end
    rx_valid = 1'b0;
  endtask

  task automatic send_write(input logic [23:0] a, input logic [15:0] d, input int gap);
    ref_mem[a[10:0]] = d;
    exp_wr.push_back({a[10:0], d});
    put_byte(8'h57, gap);
    put_byte(a[23:16], gap);
    put_byte(a[15:8], gap);
    put_byte(a[7:0], gap);
    put_byte(d[15:8], gap);
    put_byte(d[7:0], gap);
  endtask

  task automatic send_read(input logic [23:0] a, input int gap);
    logic [15:0] d;
    d = ref_mem[a[10:0]];
    exp_tx.push_back(d[15:8]);
    exp_tx.push_back(d[7:0]);
    put_byte(8'h52, gap);
    put_byte(a[23:16], gap);
    put_byte(a[15:8], gap);
    put_byte(a[7:0], gap);
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_wr.size() != 0 || exp_tx.size() != 0) && n < 2000) begin
      @(negedge clk);
      n++;
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #3;
    // R9 reset state
    chk(rx_ready == 1'b1, "R9 rx_ready after reset", rx_ready, 1);
    chk(tx_valid == 1'b0, "R9 tx_valid after reset", tx_valid, 0);
    chk(bus_wr == 1'b0, "R9 bus_wr after reset", bus_wr, 0);
    chk(bus_rd == 1'b0, "R9 bus_rd after reset", bus_rd, 0);
    @(negedge clk);
    mon_on = 1'b1;

    // R1 R2 basic write then read back
    send_write(24'h000123, 16'hBEEF, 0);
    send_read(24'h000123, 0);
    drain();

    // R4 high address bits ignored: alias write, read through another alias
    send_write(24'hFFFABC, 16'h1234, 1);
    send_read(24'h0002BC, 0);
    send_read(24'h07FABC, 2);
    drain();

    // R5 unknown command bytes dropped, parser back at command
    put_byte(8'h00, 0);
    put_byte(8'h41, 0);
    put_byte(8'hFF, 1);
    repeat (6) @(negedge clk);
    #3;
    chk(rx_ready == 1'b1 && !tx_valid, "R5 idle after junk", {rx_ready, tx_valid}, 2'b10);
    @(negedge clk);
    send_write(24'h000005, 16'hA55A, 0);
    send_read(24'h000005, 0);
    drain();

    // R6 R7 R10 stalled answer with packets behind it
    tx_mode = 2;
    @(negedge clk);
    send_read(24'h000123, 0);
    send_write(24'h000040, 16'h0F0F, 0);
    send_read(24'h000040, 0);
    send_write(24'h000123, 16'h7777, 0);
    repeat (10) @(negedge clk);
    #3;
    chk(rx_ready == 1'b0, "R6 rx_ready low with command parked", rx_ready, 0);
    chk(tx_valid == 1'b1, "R7 stalled tx_valid held", tx_valid, 1);
    @(negedge clk);
    tx_mode = 0;
    drain();

    // R10 random stream under random back-pressure
    tx_mode = 1;
    for (int k = 0; k < 40; k++) begin
      logic [23:0] a;
      a = {$urandom_range(0, 255), 5'd0, 8'(k % 6), 3'd0};
      a = {a[23:11], 8'd0, a[2:0]} | 24'(k % 6);
      if ($urandom_range(0, 1) == 1) send_write(a, 16'($urandom), $urandom_range(0, 2));
      else                           send_read(a, $urandom_range(0, 2));
    end
    tx_mode = 0;
    drain();
    chk(exp_wr.size() == 0 && exp_tx.size() == 0, "R10 all events seen",
        exp_wr.size() + exp_tx.size(), 0);
    finish_run();
  end
endmodule